// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

A sixteen-pin general-purpose I/O port. Each pin is either a software pin or a peripheral pin. A software pin is driven from an output data latch and has its driver enabled by a direction register. A peripheral pin is taken over by an on-chip peripheral, which supplies both the driven value and the driver enable. Pad levels are captured into a register on every clock. That captured value feeds port reads and the peripheral input path.

Software reaches the port through a small register interface. A 2-bit select picks one of four registers, a write enable commits the write data, and read data comes back combinationally from the selected register. Port reads mask analog-configured pins to zero. Since port reads come from the captured pad value, software has to leave one cycle between a write that changes a pin and the read that is meant to observe it.

Top module: `shared_gpio_port`

## Requirements
- R1: With no peripheral override on a pin, a direction bit of 1 disables that pin's driver (`pad_oe_o` bit 0). A direction bit of 0 enables the driver (`pad_oe_o` bit 1), and the pin drives its output latch bit on `pad_out_o`.
- R2: A write with `sel_i` = 2'b10 (latch) or `sel_i` = 2'b01 (port) loads `wdata_i` into the same output data latch. When `we_i` is low, a clock edge changes no register.
- R3: `sel_i` = 2'b00 selects the direction register and `sel_i` = 2'b11 selects the analog configuration register. Both can be written and read back. A read with `sel_i` = 2'b10 returns the output data latch.
- R4: A read with `sel_i` = 2'b01 returns the captured pad levels, with every pin whose analog configuration bit is 1 reading as 0. The masking follows the analog register at once.
- R5: When `per_en_i` bit n is 1, `pad_out_o` bit n equals `per_out_i` bit n and `pad_oe_o` bit n equals `per_oe_i` bit n, whatever the latch and direction hold.
- R6: `per_in_o` carries the captured pad levels unmasked, whether or not the pin is overridden or configured as analog.
- R7: Pad levels are captured at each rising clock edge. A port read in the cycle right after a latch write still shows the earlier pad level. The new level appears one cycle later.
- R8: On reset, the direction register is 0xFFFF (all inputs), the latch is 0x0000, the analog register is 0xFFFF (all analog), and the captured pad value is 0x0000.
- R9: A direction value of 0xFF00 leaves pins 15:8 undriven and drives pins 7:0 from the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select: 00 direction, 01 port, 10 latch, 11 analog |
| we_i | input | 1 | Write enable for the selected register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| pad_in_i | input | 16 | Pad input levels |
| pad_out_o | output | 16 | Pad output data |
| pad_oe_o | output | 16 | Pad driver enable, 1 drives |
| per_en_i | input | 16 | Per-pin peripheral override enable |
| per_out_i | input | 16 | Peripheral output data |
| per_oe_i | input | 16 | Peripheral driver enable |
| per_in_o | output | 16 | Captured pad levels for the peripheral |

## Verification
The bench loops the driven pins back onto the pad inputs. This lets it read the port immediately after a latch write and again one cycle later. A design without the capture register would show the new value too early, and one with an extra stage would show it too late. Another check reconfigures pins as analog without changing the pads. A design that masks the peripheral path, or masks only the register, would give a wrong port read or a zeroed `per_in_o`. The remaining checks cover a partial peripheral override and a write that is not committed because `we_i` is low. A design that ignores the override enable, or writes without `we_i`, would drive the wrong pins or corrupt the latch.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'b00,
    SEL_PORT = 2'b01,
    SEL_LAT  = 2'b10,
    SEL_ANA  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] ana_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] dir_q, lat_q, ana_q;
  logic         lat_wr;

  // port and latch addresses share one data latch
  assign lat_wr = we_i && (sel_i == SEL_LAT || sel_i == SEL_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= ALL_ONES;
      lat_q <= '0;
      ana_q <= ALL_ONES;
    end else begin
      if (we_i && sel_i == SEL_DIR) dir_q <= wdata_i;
      if (lat_wr)                   lat_q <= wdata_i;
      if (we_i && sel_i == SEL_ANA) ana_q <= wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
  assign ana_o = ana_q;

  p_lat_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (sel_i == SEL_LAT || sel_i == SEL_PORT)) |=> lat_q == $past(wdata_i));

  p_lat_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(lat_q) && $stable(dir_q) && $stable(ana_q));

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DIR) |=> dir_q == $past(wdata_i));
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic [W-1:0] per_en_i,
  input  logic [W-1:0] per_out_i,
  input  logic [W-1:0] per_oe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (per_en_i[i]) begin
        pad_out_o[i] = per_out_i[i];
        pad_oe_o[i]  = per_oe_i[i];
      end else begin
        pad_out_o[i] = lat_i[i];
        pad_oe_o[i]  = ~dir_i[i];  // dir 1 = input
      end
    end
  end
endmodule

// File: rtl/gpio_in_sample.sv
`timescale 1ns/1ps
module gpio_in_sample #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] smp_o
);
  logic [W-1:0] smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= pad_i;
  end

  assign smp_o = smp_q;

  p_sample_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> smp_q == $past(pad_i));
endmodule

// File: rtl/shared_gpio_port.sv
`timescale 1ns/1ps
module shared_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   sel_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  input  logic [W-1:0] per_en_i,
  input  logic [W-1:0] per_out_i,
  input  logic [W-1:0] per_oe_i,
  output logic [W-1:0] per_in_o
);
  reg_sel_e     sel;
  logic [W-1:0] dir, lat, ana, smp;

  assign sel = reg_sel_e'(sel_i);

  gpio_port_regs #(.W(W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .dir_o   (dir),
    .lat_o   (lat),
    .ana_o   (ana)
  );

  gpio_pin_mux #(.W(W)) i_mux (
    .dir_i     (dir),
    .lat_i     (lat),
    .per_en_i  (per_en_i),
    .per_out_i (per_out_i),
    .per_oe_i  (per_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  gpio_in_sample #(.W(W)) i_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .smp_o  (smp)
  );

  assign per_in_o = smp;  // unmasked

  always_comb begin
    unique case (sel)
      SEL_DIR:  rdata_o = dir;
      SEL_PORT: rdata_o = smp & ~ana;
      SEL_LAT:  rdata_o = lat;
      SEL_ANA:  rdata_o = ana;
      default:  rdata_o = '0;
    endcase
  end

  p_port_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_PORT) |-> (rdata_o & ana) == '0);

  p_input_undriven_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir & ~per_en_i) == '0);

  p_per_in_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_PORT) |-> (per_in_o & ~ana) == rdata_o);
endmodule

// File: tb/test_shared_gpio_port.sv
`timescale 1ns/1ps
module test_shared_gpio_port;
  localparam int W = 16;
  localparam int NV = 6;
  localparam int WD_CYC = 5000;

  // {sel_wr, wdata, sel_rd, expected}
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 16'hFF00, 2'b00, 16'hFF00},  // R3 / R9 direction split
    {2'b10, 16'h1234, 2'b10, 16'h1234},  // R2 latch address
    {2'b01, 16'h00C3, 2'b10, 16'h00C3},  // R2 port address hits latch
    {2'b11, 16'h0F00, 2'b11, 16'h0F00},  // R3 analog register
    {2'b00, 16'h00FF, 2'b00, 16'h00FF},  // R3
    {2'b00, 16'hFF00, 2'b00, 16'hFF00}   // R9
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pad_in, pad_out, pad_oe, per_in;
  logic [W-1:0] per_en = '0, per_out = '0, per_oe = '0;
  logic [W-1:0] ext = 16'hA5FF;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // driven pins loop back onto their pads
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  shared_gpio_port #(.W(W)) i_shared_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .per_en_i(per_en), .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    sel = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [W-1:0] d);
    sel = s;
    #1 d = rdata;
  endtask

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R8 reset state, checked during reset
    chk("R8 oe in reset", pad_oe, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'b00, v); chk("R8 dir", v, 16'hFFFF);
    rd(2'b10, v); chk("R8 lat", v, 16'h0000);
    rd(2'b11, v); chk("R8 ana", v, 16'hFFFF);
    rd(2'b01, v); chk("R8 port masked", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:34], VEC[i][33:18]);
      rd(VEC[i][17:16], v);
      chk("R2/R3 table", v, VEC[i][15:0]);
    end
    // state: dir FF00, lat 00C3, ana 0F00
    chk("R9 upper undriven", pad_oe, 16'h00FF);
    chk("R1 pad_out from latch", pad_out & pad_oe, 16'h00C3);
    @(negedge clk);
    rd(2'b01, v); chk("R4 analog masked", v, 16'hA0C3);
    wr(2'b11, 16'h0000);
    rd(2'b01, v); chk("R4 mask released", v, 16'hA5C3);

    // R7 latency
    wr(2'b10, 16'h003C);
    rd(2'b01, v); chk("R7 stale read", v, 16'hA5C3);
    @(negedge clk);
    rd(2'b01, v); chk("R7 fresh read", v, 16'hA53C);

    // R5 override on pins 1:0
    @(negedge clk);
    per_en = 16'h0003; per_out = 16'h0001; per_oe = 16'h0002;
    #1;
    chk("R5 override out", pad_out, 16'h003D);
    chk("R5 override oe", pad_oe, 16'h00FE);
    @(negedge clk);
    chk("R6 per_in", per_in, 16'hA53D);
    wr(2'b11, 16'hFFFF);
    rd(2'b01, v); chk("R4 all analog", v, 16'h0000);
    chk("R6 per_in unmasked", per_in, 16'hA53D);

    // R2 write without enable
    @(negedge clk);
    sel = 2'b10; wdata = 16'hFFFF; we = 1'b0;
    @(negedge clk);
    rd(2'b10, v); chk("R2 we low ignored", v, 16'h003C);

    // R1 full direction sweep
    per_en = '0;
    wr(2'b00, 16'hFFFF);
    chk("R1 all inputs", pad_oe, 16'h0000);
    wr(2'b00, 16'h0000);
    chk("R1 all outputs", pad_oe, 16'hFFFF);
    chk("R1 out data", pad_out, 16'h003C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule